// File: doc/BRIEF.md
# BCD Seven-Segment Decoder with Zero Suppression

This block turns one four-bit BCD digit into the seven segment drives of a numeric display, segments a through g. Three active-low controls sit in front of the decoding: a lamp-test input that forces every segment on, a blanking input that forces every segment off, and a ripple-blank input. When the ripple-blank input is asserted, a zero digit is suppressed. A ripple-blank output reports that the digit was blanked. Several copies can be chained from the most significant digit downward, so that leading zeros of a multi-digit number disappear and the first nonzero digit and everything after it are shown.

An optional hold stage freezes the displayed digit while a latch-enable input is high. The stage is a clocked register that follows the input while latch-enable is low. A parameter selects the output polarity. Active-low segments suit common-anode displays and active-high segments suit common-cathode displays. Everything is plain digital logic. Drive strength and display multiplexing are left to the surrounding design.

Top module: `segdec_top`

## Requirements
- R1: With all controls inactive (high) and latch-enable low, bcdIn (bit 3 most significant) values 0 to 9 light the standard glyphs. In active-high terms, with bit 0 = a through bit 6 = g, the patterns are: 0→0x3F, 1→0x06, 2→0x5B, 3→0x4F, 4→0x66, 5→0x6D, 6→0x7D, 7→0x07, 8→0x7F, 9→0x6F.
- R2: lampTestN low lights all seven segments for any digit and any other control, and holds rippleOutN high.
- R3: With lampTestN high, blankInN low turns all segments off and drives rippleOutN low.
- R4: With lampTestN and blankInN high, rippleInN low together with a displayed digit of 0000 turns all segments off and drives rippleOutN low.
- R5: With lampTestN and blankInN high, a nonzero digit, or rippleInN high, gives normal decoding and rippleOutN high.
- R6: Codes 1010 to 1111 with no control active give a blank display, and rippleOutN stays high.
- R7: With ACTIVE_LOW=1, segOut is the bitwise inverse of the active-high pattern. With ACTIVE_LOW=0, segOut equals the active-high pattern.
- R8: With USE_LATCH=1 and latch-enable low, the displayed digit is bcdIn. With latch-enable high, it is the bcdIn value sampled at the last rising clock edge at which latch-enable was low, and changes on bcdIn have no effect.
- R9: While rstN is low the hold register is 0, so with latch-enable high the display shows digit 0.
- R10: Four copies chained as described (top ripple input low, each rippleOutN into the next lower digit, lowest digit ripple input high) suppress leading zeros and still show a single 0 for the value zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the hold register |
| rstN | input | 1 | Asynchronous active-low reset, clears the hold register |
| bcdIn | input | 4 | BCD digit, bit 3 most significant |
| latchEn | input | 1 | High holds the displayed digit |
| lampTestN | input | 1 | Active-low lamp test |
| blankInN | input | 1 | Active-low forced blanking |
| rippleInN | input | 1 | Active-low zero suppression request |
| segOut | output | 7 | Segment drives, bit 0 = a through bit 6 = g |
| rippleOutN | output | 1 | Low when this digit is blanked |

## Verification
The bench builds the main instance with ACTIVE_LOW=1 and USE_LATCH=1. This exercises the inverted outputs, the hold register and its reset value. It also builds a four-digit chain with ACTIVE_LOW=0 and USE_LATCH=0. The chain exercises the pass-through variant, the active-high polarity, and ripple propagation across digits. With both builds, every code under every control combination, the latch capture and hold timing, and leading-zero suppression over whole numbers can all be checked.

// File: rtl/segdec_pkg.sv
package segdec_pkg;

  localparam int BCD_W = 4;
  localparam int SEG_W = 7;
  localparam logic [BCD_W-1:0] MAX_DIGIT = 4'd9;

  // Strobes from the control path into the datapath; at most one is set.
  typedef struct packed {
    logic lampOn;
    logic blankAll;
    logic rippleBlank;
  } segStrobe_t;

endpackage

// File: rtl/segdec_ctrl.sv
module segdec_ctrl
  import segdec_pkg::*;
(
  input  logic       lampTestN,
  input  logic       blankInN,
  input  logic       rippleInN,
  input  logic       digitZero,
  output segStrobe_t strobe,
  output logic       rippleOutN
);

  // Fixed priority: lamp test, forced blank, zero ripple, normal.
  always_comb begin
    strobe = '0;
    if (!lampTestN) begin
      strobe.lampOn = 1'b1;
    end else if (!blankInN) begin
      strobe.blankAll = 1'b1;
    end else if (!rippleInN && digitZero) begin
      strobe.rippleBlank = 1'b1;
    end
  end

  // A blanked digit passes the blanking on to the next lower digit.
  assign rippleOutN = !(strobe.blankAll || strobe.rippleBlank);

endmodule

// File: rtl/segdec_dp.sv
module segdec_dp
  import segdec_pkg::*;
#(
  parameter bit ACTIVE_LOW = 1'b1,
  parameter bit USE_LATCH  = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [BCD_W-1:0] bcdIn,
  input  logic             latchEn,
  input  segStrobe_t       strobe,
  output logic             digitZero,
  output logic [SEG_W-1:0] segOut
);

  logic [BCD_W-1:0] shownDigit;
  logic [SEG_W-1:0] glyph;
  logic [SEG_W-1:0] segActive;

  generate
    if (USE_LATCH) begin : g_hold
      logic [BCD_W-1:0] holdReg;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          holdReg <= '0;
        end else if (!latchEn) begin
          holdReg <= bcdIn;
        end
      end
      assign shownDigit = latchEn ? holdReg : bcdIn;
    end else begin : g_pass
      assign shownDigit = bcdIn;
    end
  endgenerate

  assign digitZero = (shownDigit == '0);

  // Active-high glyph table, bit 0 = a ... bit 6 = g.
  always_comb begin
    unique case (shownDigit)
      4'd0:    glyph = 7'h3F;
      4'd1:    glyph = 7'h06;
      4'd2:    glyph = 7'h5B;
      4'd3:    glyph = 7'h4F;
      4'd4:    glyph = 7'h66;
      4'd5:    glyph = 7'h6D;
      4'd6:    glyph = 7'h7D;
      4'd7:    glyph = 7'h07;
      4'd8:    glyph = 7'h7F;
      4'd9:    glyph = 7'h6F;
      default: glyph = '0;
    endcase
  end

  always_comb begin
    if (strobe.lampOn) begin
      segActive = '1;
    end else if (strobe.blankAll || strobe.rippleBlank) begin
      segActive = '0;
    end else begin
      segActive = glyph;
    end
  end

  generate
    if (ACTIVE_LOW) begin : g_anode
      assign segOut = ~segActive;
    end else begin : g_cathode
      assign segOut = segActive;
    end
  endgenerate

endmodule

// File: rtl/segdec_top.sv
module segdec_top
  import segdec_pkg::*;
#(
  parameter bit ACTIVE_LOW = 1'b1,
  parameter bit USE_LATCH  = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] bcdIn,
  input  logic       latchEn,
  input  logic       lampTestN,
  input  logic       blankInN,
  input  logic       rippleInN,
  output logic [6:0] segOut,
  output logic       rippleOutN
);

  segStrobe_t strobe;
  logic       digitZero;

  segdec_ctrl u_ctrl (
    .lampTestN (lampTestN),
    .blankInN  (blankInN),
    .rippleInN (rippleInN),
    .digitZero (digitZero),
    .strobe    (strobe),
    .rippleOutN(rippleOutN)
  );

  segdec_dp #(
    .ACTIVE_LOW(ACTIVE_LOW),
    .USE_LATCH (USE_LATCH)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .bcdIn    (bcdIn),
    .latchEn  (latchEn),
    .strobe   (strobe),
    .digitZero(digitZero),
    .segOut   (segOut)
  );

endmodule

// File: rtl/segdec_chk.sv
module segdec_chk #(
  parameter bit ACTIVE_LOW = 1'b1
) (
  input logic       clk,
  input logic       rstN,
  input logic [3:0] bcdIn,
  input logic       latchEn,
  input logic       lampTestN,
  input logic       blankInN,
  input logic       rippleInN,
  input logic [6:0] segOut,
  input logic       rippleOutN
);

  logic [6:0] segOn;
  assign segOn = ACTIVE_LOW ? ~segOut : segOut;

  p_lamp_all_on_r2: assert property (@(posedge clk) disable iff (!rstN)
    !lampTestN |-> (segOn == 7'h7F) && rippleOutN);

  p_blank_all_off_r3: assert property (@(posedge clk) disable iff (!rstN)
    (lampTestN && !blankInN) |-> (segOn == 7'h00) && !rippleOutN);

  p_ripple_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (lampTestN && blankInN && !rippleInN && !latchEn && bcdIn == 4'd0)
      |-> !rippleOutN && (segOn == 7'h00));

  p_rbo_means_dark_r4: assert property (@(posedge clk) disable iff (!rstN)
    !rippleOutN |-> (segOn == 7'h00));

  p_nonbcd_dark_r6: assert property (@(posedge clk) disable iff (!rstN)
    (lampTestN && blankInN && !latchEn && bcdIn > 4'd9)
      |-> (segOn == 7'h00) && rippleOutN);

  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    (latchEn && $past(latchEn) && $stable({lampTestN, blankInN, rippleInN}))
      |-> $stable(segOut));

endmodule

bind segdec_top segdec_chk #(.ACTIVE_LOW(ACTIVE_LOW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .bcdIn     (bcdIn),
  .latchEn   (latchEn),
  .lampTestN (lampTestN),
  .blankInN  (blankInN),
  .rippleInN (rippleInN),
  .segOut    (segOut),
  .rippleOutN(rippleOutN)
);

// File: tb/tb_segdec_top.sv
module tb_segdec_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] bcdIn = 4'd5;
  logic       latchEn = 1'b1;
  logic       lampTestN = 1'b1;
  logic       blankInN = 1'b1;
  logic       rippleInN = 1'b1;
  logic [6:0] segOut;
  logic       rippleOutN;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  segdec_top #(.ACTIVE_LOW(1'b1), .USE_LATCH(1'b1)) dut (
    .clk(clk), .rstN(rstN), .bcdIn(bcdIn), .latchEn(latchEn),
    .lampTestN(lampTestN), .blankInN(blankInN), .rippleInN(rippleInN),
    .segOut(segOut), .rippleOutN(rippleOutN)
  );

  // Four-digit chain, active-high, no hold stage. Index 3 is most significant.
  logic [3:0] chainBcd [4];
  logic [6:0] chainSeg [4];
  logic       chainRbo [4];

  segdec_top #(.ACTIVE_LOW(1'b0), .USE_LATCH(1'b0)) u_d3 (
    .clk(clk), .rstN(rstN), .bcdIn(chainBcd[3]), .latchEn(1'b0),
    .lampTestN(1'b1), .blankInN(1'b1), .rippleInN(1'b0),
    .segOut(chainSeg[3]), .rippleOutN(chainRbo[3]));
  segdec_top #(.ACTIVE_LOW(1'b0), .USE_LATCH(1'b0)) u_d2 (
    .clk(clk), .rstN(rstN), .bcdIn(chainBcd[2]), .latchEn(1'b0),
    .lampTestN(1'b1), .blankInN(1'b1), .rippleInN(chainRbo[3]),
    .segOut(chainSeg[2]), .rippleOutN(chainRbo[2]));
  segdec_top #(.ACTIVE_LOW(1'b0), .USE_LATCH(1'b0)) u_d1 (
    .clk(clk), .rstN(rstN), .bcdIn(chainBcd[1]), .latchEn(1'b0),
    .lampTestN(1'b1), .blankInN(1'b1), .rippleInN(chainRbo[2]),
    .segOut(chainSeg[1]), .rippleOutN(chainRbo[1]));
  segdec_top #(.ACTIVE_LOW(1'b0), .USE_LATCH(1'b0)) u_d0 (
    .clk(clk), .rstN(rstN), .bcdIn(chainBcd[0]), .latchEn(1'b0),
    .lampTestN(1'b1), .blankInN(1'b1), .rippleInN(1'b1),
    .segOut(chainSeg[0]), .rippleOutN(chainRbo[0]));

  // Active-high glyphs from R1.
  function automatic logic [6:0] refGlyph(input logic [3:0] d);
    case (d)
      4'd0: return 7'h3F;  4'd1: return 7'h06;  4'd2: return 7'h5B;
      4'd3: return 7'h4F;  4'd4: return 7'h66;  4'd5: return 7'h6D;
      4'd6: return 7'h7D;  4'd7: return 7'h07;  4'd8: return 7'h7F;
      4'd9: return 7'h6F;  default: return 7'h00;
    endcase
  endfunction

  task automatic checkVal(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Fields: lampTestN, blankInN, rippleInN, bcd[3:0], active-high seg[6:0], rippleOutN
  localparam logic [14:0] VEC [20] = '{
    15'b1_1_1_0000_0111111_1, 15'b1_1_1_0001_0000110_1,
    15'b1_1_1_0010_1011011_1, 15'b1_1_1_0011_1001111_1,
    15'b1_1_1_0100_1100110_1, 15'b1_1_1_0101_1101101_1,
    15'b1_1_1_0110_1111101_1, 15'b1_1_1_0111_0000111_1,
    15'b1_1_1_1000_1111111_1, 15'b1_1_1_1001_1101111_1,
    15'b1_1_1_1010_0000000_1, 15'b1_1_1_1111_0000000_1,
    15'b1_1_0_0000_0000000_0, 15'b1_1_0_0101_1101101_1,
    15'b1_1_0_1100_0000000_1, 15'b0_1_1_0000_1111111_1,
    15'b0_1_0_0000_1111111_1, 15'b0_0_1_1111_1111111_1,
    15'b1_0_1_0011_0000000_0, 15'b1_0_0_0000_0000000_0
  };

  task automatic checkChain(input string req, input int value);
    logic [6:0] expSeg [4];
    logic       expRbo [4];
    logic       blankUp;
    blankUp = 1'b1;
    for (int k = 3; k >= 0; k--) begin
      chainBcd[k] = 4'((value / (10 ** k)) % 10);
    end
    for (int k = 3; k >= 0; k--) begin
      if (k != 0 && blankUp && chainBcd[k] == 4'd0) begin
        expSeg[k] = 7'h00; expRbo[k] = 1'b0;
      end else begin
        blankUp = 1'b0;
        expSeg[k] = refGlyph(chainBcd[k]); expRbo[k] = 1'b1;
      end
    end
    #2;
    for (int k = 3; k >= 0; k--) begin
      checkVal(req, {chainRbo[k], chainSeg[k]}, {expRbo[k], expSeg[k]});
    end
  endtask

  initial begin
    for (int k = 0; k < 4; k++) chainBcd[k] = 4'd0;
    // R9: reset state with hold selected shows digit 0 (active-low output)
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkVal("R9 reset hold value", {rippleOutN, segOut}, {1'b1, ~7'h3F});
    rstN = 1'b1;
    latchEn = 1'b0;

    // Table of directed vectors (R1..R6), active-low dut so R7 inverts.
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      {lampTestN, blankInN, rippleInN, bcdIn} = VEC[i][14:8];
      #1;
      if (!VEC[i][14])      checkVal("R2 table", {rippleOutN, ~segOut}, {VEC[i][0], VEC[i][7:1]});
      else if (!VEC[i][13]) checkVal("R3 table", {rippleOutN, ~segOut}, {VEC[i][0], VEC[i][7:1]});
      else if (VEC[i][11:8] > 4'd9) checkVal("R6 table", {rippleOutN, ~segOut}, {VEC[i][0], VEC[i][7:1]});
      else if (!VEC[i][12] && VEC[i][11:8] == 4'd0) checkVal("R4 table", {rippleOutN, ~segOut}, {VEC[i][0], VEC[i][7:1]});
      else checkVal("R1 table", {rippleOutN, ~segOut}, {VEC[i][0], VEC[i][7:1]});
    end

    // Full sweep: every code under every control combination (R5 priority).
    for (int c = 0; c < 8; c++) begin
      for (int d = 0; d < 16; d++) begin
        logic [6:0] expSeg;
        logic       expRbo;
        @(negedge clk);
        {lampTestN, blankInN, rippleInN} = 3'(c);
        bcdIn = 4'(d);
        if (!lampTestN) begin expSeg = 7'h7F; expRbo = 1'b1; end
        else if (!blankInN) begin expSeg = 7'h00; expRbo = 1'b0; end
        else if (!rippleInN && d == 0) begin expSeg = 7'h00; expRbo = 1'b0; end
        else begin expSeg = refGlyph(4'(d)); expRbo = 1'b1; end
        #1;
        checkVal("R5 sweep", {rippleOutN, segOut}, {expRbo, ~expSeg});
      end
    end

    // R8: capture then hold.
    @(negedge clk);
    {lampTestN, blankInN, rippleInN} = 3'b111;
    bcdIn = 4'd7; latchEn = 1'b0;
    @(negedge clk);
    latchEn = 1'b1; bcdIn = 4'd2;
    #1;
    checkVal("R8 hold after rise", {rippleOutN, segOut}, {1'b1, ~7'h07});
    @(negedge clk);
    bcdIn = 4'd0; rippleInN = 1'b0;
    #1;
    checkVal("R8 input ignored", {rippleOutN, segOut}, {1'b1, ~7'h07});
    @(negedge clk);
    latchEn = 1'b0;
    #1;
    checkVal("R8 transparent again", {rippleOutN, segOut}, {1'b0, 7'h7F});
    rippleInN = 1'b1;

    // R7: same digit, two polarities.
    @(negedge clk);
    bcdIn = 4'd3;
    chainBcd[0] = 4'd3; chainBcd[1] = 4'd0; chainBcd[2] = 4'd0; chainBcd[3] = 4'd0;
    #1;
    checkVal("R7 active low", {1'b0, segOut}, {1'b0, 7'b0110000});
    checkVal("R7 active high", {1'b0, chainSeg[0]}, {1'b0, 7'b1001111});

    // R10: chained leading-zero suppression.
    checkChain("R10 0030", 30);
    checkChain("R10 0000", 0);
    checkChain("R10 1005", 1005);
    checkChain("R10 0700", 700);
    checkChain("R10 9999", 9999);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule